// File: doc/BRIEF.md
# LCD Pixel Scan-Out with Marker Realignment

This block drives a parallel RGB panel from the pixel clock domain. It counts the horizontal and vertical raster of a 480x272 panel at 9 MHz. It takes pixel words from the read side of a show-ahead clock-crossing FIFO, and the FIFO hands over the word at its head whenever it is not empty. Each word carries two flag bits with it. One marks the first pixel of a frame and the other marks the first pixel of a line. The block compares these flags with its own raster position, and a word is shown only when its flags agree with that position.

The block does not trust the order of the data. If the FIFO runs dry during the visible area, or if a word carries the wrong flags, the block shows black. It then drops words until it reaches a frame-start word, keeps that word at the FIFO head, and locks again at the first visible pixel of the next frame. A sticky flag records that an underflow has happened. The upstream fetch engine only has to keep the FIFO full and tag its words correctly.

Top module: `lcd_scanout`

## Requirements
- R1: While reset is held, both sync outputs are asserted (low), and data-enable, the pop strobe, the underflow flag and the pixel bus are all zero.
- R2: A line lasts H_SYNC+H_BACK+H_ACT+H_FRONT clocks. `hsync_n_o` is low for the first H_SYNC clocks of the line. On active lines, `de_o` is high for H_ACT clocks starting H_SYNC+H_BACK clocks after the line starts.
- R3: A frame lasts V_SYNC+V_BACK+V_ACT+V_FRONT lines. `vsync_n_o` is low for the first V_SYNC lines. The active lines are the V_ACT lines that start V_SYNC+V_BACK lines after the frame starts. Both counters start at line 0, clock 0 when reset is released.
- R4: `fifo_pop_o` rises only while `de_o` is high and `fifo_empty_i` is low. It pops at most one word per clock.
- R5: While locked, a head word whose flags match the raster is driven on `pix_o` in the same clock and is popped.
- R6: The expected flags are as follows. `fifo_sof_i`=1 only at the first active pixel of a frame. `fifo_sol_i`=1 only at the first active pixel of every active line. Both are 0 everywhere else.
- R7: After reset the block is not locked. It shows black until, at the first active pixel of a frame, the head word has both flags set.
- R8: While unlocked, during `de_o` the block shows black. It pops and drops head words that have `fifo_sof_i`=0. It leaves a word with `fifo_sof_i`=1 in the FIFO until the first active pixel of a frame.
- R9: While locked, a head word with mismatching flags is shown as black and the block unlocks. That word is popped unless `fifo_sof_i`=1.
- R10: An empty FIFO during `de_o` gives black with no pop. In the next clock `underflow_o` goes high and stays high until reset. The block unlocks, so the rest of that frame is black.
- R11: `pix_o` is zero whenever `de_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk_pix |
| fifo_empty_i | input | 1 | FIFO read side has no word |
| fifo_pix_i | input | PIX_W | Pixel value of the head word |
| fifo_sof_i | input | 1 | Head word is flagged as frame start |
| fifo_sol_i | input | 1 | Head word is flagged as line start |
| fifo_pop_o | output | 1 | Consume the head word at this clock edge |
| pix_o | output | PIX_W | Pixel to the panel, zero when blanked |
| de_o | output | 1 | Data enable, high in the visible area |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| vsync_n_o | output | 1 | Vertical sync, active low |
| underflow_o | output | 1 | Sticky: FIFO was empty during the visible area |

## Verification
The bench shrinks the raster to a few pixels and lines and runs nine whole frames. It compares every output on every clock with values computed from the clock count and from the FIFO contents the bench holds. The stream starts with untagged garbage, which separates the initial hunt from a correct lock. A frame with a missing line-start flag separates a mid-frame marker mismatch from ordinary display. A frame cut off halfway separates underflow blanking and its sticky flag from the recovery that follows at the next frame start. Counting the consumed words at each stage shows which words were dropped and which were kept for the next frame.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic {
    ALN_HUNT = 1'b0,
    ALN_LOCK = 1'b1
  } aln_state_e;

  // True when cnt lies in [start, start+len)
  function automatic logic in_span(input int unsigned cnt,
                                   input int unsigned start,
                                   input int unsigned len);
    return (cnt >= start) && (cnt < start + len);
  endfunction

  // Flags of a word agree with the raster position
  function automatic logic markers_fit(input logic sof, input logic sol,
                                       input logic at_frame, input logic at_line);
    return (sof == at_frame) && (sol == at_line);
  endfunction

endpackage

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
  import lcd_scan_pkg::*;
#(
  parameter int H_SYNC  = 2,
  parameter int H_BACK  = 2,
  parameter int H_ACT   = 480,
  parameter int H_FRONT = 41,
  parameter int V_SYNC  = 10,
  parameter int V_BACK  = 2,
  parameter int V_ACT   = 272,
  parameter int V_FRONT = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic hsync_n,
  output logic vsync_n,
  output logic active,
  output logic frame_first,
  output logic line_first
);
  localparam int H_TOTAL = H_SYNC + H_BACK + H_ACT + H_FRONT;
  localparam int V_TOTAL = V_SYNC + V_BACK + V_ACT + V_FRONT;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT0 = HW'(H_SYNC + H_BACK);
  localparam logic [VW-1:0] V_ACT0 = VW'(V_SYNC + V_BACK);

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_vis, v_vis;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else if (h_cnt == H_LAST) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  always_comb begin
    h_vis       = in_span(32'(h_cnt), H_SYNC + H_BACK, H_ACT);
    v_vis       = in_span(32'(v_cnt), V_SYNC + V_BACK, V_ACT);
    hsync_n     = !in_span(32'(h_cnt), 0, H_SYNC);
    vsync_n     = !in_span(32'(v_cnt), 0, V_SYNC);
    active      = h_vis && v_vis;
    line_first  = active && (h_cnt == H_ACT0);
    frame_first = line_first && (v_cnt == V_ACT0);
  end

endmodule

// File: rtl/lcd_align_fsm.sv
module lcd_align_fsm
  import lcd_scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic frame_first,
  input  logic line_first,
  input  logic fifo_empty,
  input  logic head_sof,
  input  logic head_sol,
  output logic show,
  output logic pop,
  output logic locked,
  output logic underflow
);
  aln_state_e state_q, state_d;
  logic       ufl_q, ufl_hit, fit;

  always_comb begin
    state_d = state_q;
    show    = 1'b0;
    pop     = 1'b0;
    ufl_hit = 1'b0;
    fit     = markers_fit(head_sof, head_sol, frame_first, line_first);
    if (active) begin
      if (fifo_empty) begin
        ufl_hit = 1'b1;
        state_d = ALN_HUNT;
      end else begin
        show    = (state_q == ALN_LOCK) ? fit : (frame_first && fit);
        pop     = show || !head_sof;
        state_d = show ? ALN_LOCK : ALN_HUNT;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ALN_HUNT;
      ufl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ufl_q   <= ufl_q | ufl_hit;
    end
  end

  assign locked    = (state_q == ALN_LOCK);
  assign underflow = ufl_q;

endmodule

// File: rtl/lcd_scanout.sv
module lcd_scanout #(
  parameter int PIX_W   = 24,
  parameter int H_SYNC  = 2,
  parameter int H_BACK  = 2,
  parameter int H_ACT   = 480,
  parameter int H_FRONT = 41,
  parameter int V_SYNC  = 10,
  parameter int V_BACK  = 2,
  parameter int V_ACT   = 272,
  parameter int V_FRONT = 4
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic             fifo_empty_i,
  input  logic [PIX_W-1:0] fifo_pix_i,
  input  logic             fifo_sof_i,
  input  logic             fifo_sol_i,
  output logic             fifo_pop_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             de_o,
  output logic             hsync_n_o,
  output logic             vsync_n_o,
  output logic             underflow_o
);
  // Internal events, named for the checker
  logic active_w, frame_first_w, line_first_w;
  logic show_w, locked_w;

  lcd_raster_gen #(
    .H_SYNC(H_SYNC), .H_BACK(H_BACK), .H_ACT(H_ACT), .H_FRONT(H_FRONT),
    .V_SYNC(V_SYNC), .V_BACK(V_BACK), .V_ACT(V_ACT), .V_FRONT(V_FRONT)
  ) u_raster (
    .clk         (clk_pix),
    .rst_n       (rst_n),
    .hsync_n     (hsync_n_o),
    .vsync_n     (vsync_n_o),
    .active      (active_w),
    .frame_first (frame_first_w),
    .line_first  (line_first_w)
  );

  lcd_align_fsm u_align (
    .clk         (clk_pix),
    .rst_n       (rst_n),
    .active      (active_w),
    .frame_first (frame_first_w),
    .line_first  (line_first_w),
    .fifo_empty  (fifo_empty_i),
    .head_sof    (fifo_sof_i),
    .head_sol    (fifo_sol_i),
    .show        (show_w),
    .pop         (fifo_pop_o),
    .locked      (locked_w),
    .underflow   (underflow_o)
  );

  assign de_o  = active_w;
  assign pix_o = show_w ? fifo_pix_i : '0;

endmodule

// File: rtl/lcd_scanout_chk.sv
module lcd_scanout_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             de,
  input logic             pop,
  input logic             empty,
  input logic             head_sof,
  input logic             hsync_n,
  input logic             underflow,
  input logic             show,
  input logic             locked,
  input logic             frame_first,
  input logic [PIX_W-1:0] pix
);
  p_pop_in_de_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (de && !empty));

  p_show_pops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    show |-> pop);

  p_hunt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && de && !empty && head_sof && !frame_first) |-> !pop);

  p_hunt_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !frame_first) |-> (pix == '0));

  p_ufl_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (de && empty) |=> (underflow && !locked));

  p_ufl_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);

  p_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> (pix == '0));

  p_no_de_in_hsync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_n |-> !de);

endmodule

bind lcd_scanout lcd_scanout_chk #(.PIX_W(PIX_W)) u_chk (
  .clk         (clk_pix),
  .rst_n       (rst_n),
  .de          (de_o),
  .pop         (fifo_pop_o),
  .empty       (fifo_empty_i),
  .head_sof    (fifo_sof_i),
  .hsync_n     (hsync_n_o),
  .underflow   (underflow_o),
  .show        (show_w),
  .locked      (locked_w),
  .frame_first (frame_first_w),
  .pix         (pix_o)
);

// File: tb/test_lcd_scanout.sv
`timescale 1ns/1ps
module test_lcd_scanout;
  localparam int PW = 16;
  localparam int HS = 2, HB = 2, HA = 8, HF = 3;
  localparam int VS = 2, VB = 1, VA = 4, VF = 2;
  localparam int HT = HS + HB + HA + HF;
  localparam int VT = VS + VB + VA + VF;
  localparam int FR = HT * VT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PW-1:0] pix;
  logic de, hs_n, vs_n, pop, ufl;

  logic [PW+1:0] mem [0:1023];   // {sof, sol, pixel}
  int rd = 0;
  int wr = 0;
  int wr_pend = 0;
  int t = 0;
  int vectors = 0;
  int errors = 0;
  logic m_hunt = 1'b1;
  logic m_ufl = 1'b0;

  wire f_empty = (rd == wr);
  wire [PW+1:0] head = mem[rd[9:0]];

  always #5 clk = ~clk;

  always @(posedge clk) if (rst_n && pop) rd <= rd + 1;

  lcd_scanout #(
    .PIX_W(PW), .H_SYNC(HS), .H_BACK(HB), .H_ACT(HA), .H_FRONT(HF),
    .V_SYNC(VS), .V_BACK(VB), .V_ACT(VA), .V_FRONT(VF)
  ) i_lcd_scanout (
    .clk_pix(clk), .rst_n(rst_n), .fifo_empty_i(f_empty),
    .fifo_pix_i(head[PW-1:0]), .fifo_sof_i(head[PW+1]), .fifo_sol_i(head[PW]),
    .fifo_pop_o(pop), .pix_o(pix), .de_o(de), .hsync_n_o(hs_n),
    .vsync_n_o(vs_n), .underflow_o(ufl)
  );

  task automatic push(input logic sof, input logic sol, input logic [PW-1:0] v);
    mem[wr_pend[9:0]] = {sof, sol, v};
    wr_pend++;
  endtask

  // bad_line: line whose line-start flag is dropped; nwords: words pushed
  task automatic push_frame(input int fr, input int bad_line, input int nwords);
    int n = 0;
    for (int l = 0; l < VA; l++)
      for (int c = 0; c < HA; c++) begin
        if (n < nwords)
          push(l == 0 && c == 0, c == 0 && l != bad_line, PW'(fr * 256 + l * 16 + c + 1));
        n++;
      end
  endtask

  task automatic expect_eq(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s t=%0d actual=%0d expected=%0d", req, what, t, act, exp);
    end
  endtask

  task automatic check_cycle();
    int h = t % HT;
    int v = (t / HT) % VT;
    logic act = (h >= HS + HB) && (h < HS + HB + HA) && (v >= VS + VB) && (v < VS + VB + VA);
    logic lf = act && (h == HS + HB);
    logic ff = lf && (v == VS + VB);
    logic emp = (rd == wr);
    logic show = 1'b0, epop = 1'b0, fit;
    string tag;
    fit = (head[PW+1] == ff) && (head[PW] == lf);
    if (!act) tag = "R11";
    else if (emp) tag = "R10";
    else begin
      show = m_hunt ? (ff && fit) : fit;
      epop = show || !head[PW+1];
      if (show) tag = (ff || lf) ? "R6" : "R5";
      else if (m_hunt) tag = (t < FR) ? "R7" : "R8";
      else tag = "R9";
    end
    vectors++;
    if (de !== act || hs_n !== !(h < HS) || vs_n !== !(v < VS) || pop !== epop ||
        pix !== (show ? head[PW-1:0] : '0) || ufl !== m_ufl) begin
      errors++;
      if (de !== act) $display("FAIL R2 de t=%0d actual=%0b expected=%0b", t, de, act);
      if (hs_n !== !(h < HS)) $display("FAIL R2 hsync t=%0d actual=%0b expected=%0b", t, hs_n, !(h < HS));
      if (vs_n !== !(v < VS)) $display("FAIL R3 vsync t=%0d actual=%0b expected=%0b", t, vs_n, !(v < VS));
      if (pop !== epop) $display("FAIL R4/%s pop t=%0d actual=%0b expected=%0b", tag, t, pop, epop);
      if (pix !== (show ? head[PW-1:0] : '0))
        $display("FAIL %s pix t=%0d actual=%0h expected=%0h", tag, t, pix, show ? head[PW-1:0] : '0);
      if (ufl !== m_ufl) $display("FAIL R10 underflow t=%0d actual=%0b expected=%0b", t, ufl, m_ufl);
    end
    if (act) begin
      if (emp) begin m_hunt = 1'b1; m_ufl = 1'b1; end
      else m_hunt = !show;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1 wr = wr_pend;
      #2 t++;
      check_cycle();
    end
  endtask

  initial begin
    // Garbage without flags, then three clean frames
    for (int i = 0; i < 3; i++) push(1'b0, 1'b0, PW'(16'hEE00 + i));
    push_frame(0, -1, HA * VA);
    push_frame(1, -1, HA * VA);
    push_frame(2, -1, HA * VA);
    wr = wr_pend;
    repeat (4) @(posedge clk);
    #3;
    // R1: reset state
    expect_eq("R1", "hsync_n", int'(hs_n), 0);
    expect_eq("R1", "vsync_n", int'(vs_n), 0);
    expect_eq("R1", "de", int'(de), 0);
    expect_eq("R1", "pop", int'(pop), 0);
    expect_eq("R1", "underflow", int'(ufl), 0);
    expect_eq("R1", "pix", int'(pix), 0);
    @(negedge clk) rst_n = 1'b1;

    // R7/R8: hunt through garbage, lock at frame 1
    run(3 * FR);
    expect_eq("R8", "words consumed", rd, 3 + 2 * HA * VA);

    // R9: line 2 of frame 3 loses its line-start flag
    push_frame(3, 2, HA * VA);
    push_frame(4, -1, HA * VA);
    run(2 * FR);
    expect_eq("R9", "words consumed", rd, 3 + 4 * HA * VA);

    // R10: half a frame then starvation
    push_frame(5, -1, HA * VA / 2);
    run(2 * FR);
    expect_eq("R10", "underflow", int'(ufl), 1);
    expect_eq("R10", "words consumed", rd, 3 + 5 * HA * VA + HA * VA / 2);

    // R10: recovery at the next frame start, flag stays set
    push_frame(6, -1, HA * VA);
    push_frame(7, -1, HA * VA);
    run(2 * FR);
    expect_eq("R10", "words consumed", rd, 3 + 7 * HA * VA + HA * VA / 2);
    expect_eq("R10", "underflow sticky", int'(ufl), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog t=%0d actual=running expected=done", t);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule